// File: doc/BRIEF.md
# QPSK Carrier Recovery Loop with Acquisition Sweep

This block recovers the carrier of a QPSK signal. Each accepted pair of filtered baseband samples yields a decision-directed phase error. A proportional plus integral loop filter turns that error into a frequency correction. The correction steers a phase-accumulator oscillator, whose upper phase bits address the sine/cosine table of the mixer upstream.

While the loop has no lock, a triangle-wave offset is added to the oscillator frequency. This sweeps the carrier uncertainty range so that the loop can pull in. A windowed lock detector watches how far the symbols sit from the constellation diagonals. Once the loop is locked the detector freezes the sweep and raises a flag that marks downstream data as valid. When lock is lost the sweep continues from where it stopped. An active-low reset returns the loop to the sweeping state.

Top module: `costas_carrier_loop`

## Requirements
- R1: While rst_ni is low, lock_o is 0, nco_phase_o is 0 and nco_freq_o equals NOM_WORD. The integrator, the proportional term and the sweep offset are zero, and the sweep direction is upward.
- R2: An accepted sample (smp_vld_i high at a clock edge) yields the phase error e = s(I)*Q - s(Q)*I, where s(x) is +1 for x >= 0 and -1 for x < 0. The error is registered at that edge and is applied by the loop filter at the following edge.
- R3: Each applied error adds e * 2^KI_SH to the signed integrator. The integrator saturates at +INT_LIM and -INT_LIM.
- R4: Each applied error replaces the proportional term with e * 2^KP_SH. The term holds until the next applied error.
- R5: nco_freq_o = NOM_WORD + integrator + proportional term + sweep offset, modulo 2^ACC_W. The phase accumulator adds nco_freq_o on every clock. nco_phase_o is its top PH_W bits.
- R6: While unlocked, a divider counts clocks. Every SWEEP_DIV clocks the sweep offset moves by SWEEP_STEP in the current direction. A move that reaches or passes +SWEEP_LIM or -SWEEP_LIM clamps the offset to that limit and reverses the direction.
- R7: While lock_o is 1, the sweep offset and its divider hold their values. When lock_o returns to 0, stepping resumes from the held state.
- R8: The lock detector sums ||I|-|Q|| over windows of WIN accepted samples. At the end of each window the flag is updated: an unlocked loop locks if the sum is below ENTER_TH, and a locked loop unlocks if the sum is above EXIT_TH. Otherwise the flag keeps its value.
- R9: A clock edge with smp_vld_i low ignores i_smp_i and q_smp_i. It changes neither the integrator, the proportional term, nor the lock-detector window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe for i_smp_i and q_smp_i |
| i_smp_i | input | DATA_W | In-phase baseband sample, two's complement |
| q_smp_i | input | DATA_W | Quadrature baseband sample, two's complement |
| nco_phase_o | output | PH_W | Oscillator phase index for the sine/cosine table |
| nco_freq_o | output | ACC_W | Current oscillator frequency word |
| lock_o | output | 1 | Carrier lock flag, qualifies output data |

## Verification
The assertions assume that reset is applied for at least one clock edge before operation. They also assume that INT_LIM and SWEEP_LIM fit in a signed ACC_W word, and that the sample strobe is always a known level. Sample values may be anything. The stimulus changes samples and strobe only on the falling clock edge. It keeps sample magnitudes within +/-100, so both the random mix and the directed patterns stay in range. The directed patterns cover on-diagonal symbols (lock), off-diagonal symbols (unlock) and an intermediate spread that falls between the two thresholds.

// File: rtl/costas_pkg.sv
package costas_pkg;
  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DN = 1'b1} sweep_dir_e;
endpackage

// File: rtl/costas_phase_det.sv
module costas_phase_det #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = DATA_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic signed [ERR_W-1:0]  err_o,
  output logic                     err_vld_o
);
  logic signed [ERR_W-1:0] i_ext, q_ext, err_d;

  assign i_ext = ERR_W'(i_i);
  assign q_ext = ERR_W'(q_i);

  // s(I)*Q - s(Q)*I, zero counts as positive
  always_comb begin
    err_d = (i_i[DATA_W-1] ? -q_ext : q_ext) - (q_i[DATA_W-1] ? -i_ext : i_ext);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o     <= '0;
      err_vld_o <= 1'b0;
    end else begin
      err_vld_o <= vld_i;
      if (vld_i) err_o <= err_d;
    end
  end
endmodule

// File: rtl/costas_loop_filter.sv
module costas_loop_filter #(
  parameter int ERR_W   = 10,
  parameter int ACC_W   = 24,
  parameter int KP_SH   = 6,
  parameter int KI_SH   = 2,
  parameter int INT_LIM = 8192
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_vld_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ACC_W-1:0] integ_o,
  output logic signed [ACC_W-1:0] prop_o
);
  localparam int AW1 = ACC_W + 1;
  localparam logic signed [AW1-1:0] LIM_P = AW1'(INT_LIM);
  localparam logic signed [AW1-1:0] LIM_N = -LIM_P;

  logic signed [ACC_W-1:0] err_ext;
  logic signed [AW1-1:0]   sum;

  assign err_ext = ACC_W'(err_i);
  assign sum     = AW1'(integ_o) + AW1'(err_ext <<< KI_SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_o <= '0;
      prop_o  <= '0;
    end else if (err_vld_i) begin
      prop_o <= err_ext <<< KP_SH;
      if (sum > LIM_P)      integ_o <= LIM_P[ACC_W-1:0];
      else if (sum < LIM_N) integ_o <= LIM_N[ACC_W-1:0];
      else                  integ_o <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/costas_sweep.sv
module costas_sweep
  import costas_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int SWEEP_STEP = 64,
  parameter int SWEEP_LIM  = 2048,
  parameter int SWEEP_DIV  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  output logic signed [ACC_W-1:0] off_o
);
  localparam int DIV_W = (SWEEP_DIV > 1) ? $clog2(SWEEP_DIV) : 1;
  localparam logic [DIV_W-1:0]        DIV_END = DIV_W'(SWEEP_DIV - 1);
  localparam logic signed [ACC_W-1:0] STEP_S  = ACC_W'(SWEEP_STEP);
  localparam logic signed [ACC_W-1:0] LIM_P   = ACC_W'(SWEEP_LIM);
  localparam logic signed [ACC_W-1:0] LIM_N   = -LIM_P;

  sweep_dir_e              dir_q;
  logic [DIV_W-1:0]        div_q;
  logic signed [ACC_W-1:0] nxt;

  assign nxt = (dir_q == SWEEP_UP) ? off_o + STEP_S : off_o - STEP_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o <= '0;
      dir_q <= SWEEP_UP;
      div_q <= '0;
    end else if (!hold_i) begin
      if (div_q == DIV_END) begin
        div_q <= '0;
        if (dir_q == SWEEP_UP && nxt >= LIM_P) begin
          off_o <= LIM_P;
          dir_q <= SWEEP_DN;
        end else if (dir_q == SWEEP_DN && nxt <= LIM_N) begin
          off_o <= LIM_N;
          dir_q <= SWEEP_UP;
        end else begin
          off_o <= nxt;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/costas_lock_det.sv
module costas_lock_det #(
  parameter int DATA_W   = 8,
  parameter int WIN      = 16,
  parameter int ENTER_TH = 64,
  parameter int EXIT_TH  = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic                     lock_o
);
  localparam int MAG_W = DATA_W + 1;
  localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SUM_W = MAG_W + CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WIN - 1);
  localparam logic [SUM_W-1:0] EN_T    = SUM_W'(ENTER_TH);
  localparam logic [SUM_W-1:0] EX_T    = SUM_W'(EXIT_TH);

  function automatic logic [MAG_W-1:0] mag_f(input logic signed [DATA_W-1:0] x);
    logic signed [MAG_W-1:0] t;
    t = MAG_W'(x);
    return t[MAG_W-1] ? $unsigned(-t) : $unsigned(t);
  endfunction

  logic [MAG_W-1:0] ai, aq, metric;
  logic [SUM_W-1:0] sum_q, tot;
  logic [CNT_W-1:0] cnt_q;

  assign ai     = mag_f(i_i);
  assign aq     = mag_f(q_i);
  assign metric = (ai > aq) ? ai - aq : aq - ai;
  assign tot    = sum_q + SUM_W'(metric);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      lock_o <= 1'b0;
    end else if (vld_i) begin
      if (cnt_q == CNT_END) begin
        sum_q <= '0;
        cnt_q <= '0;
        if (!lock_o && tot < EN_T)     lock_o <= 1'b1;
        else if (lock_o && tot > EX_T) lock_o <= 1'b0;
      end else begin
        sum_q <= tot;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/costas_carrier_loop.sv
module costas_carrier_loop #(
  parameter int               DATA_W     = 8,
  parameter int               ACC_W      = 24,
  parameter int               PH_W       = 10,
  parameter logic [ACC_W-1:0] NOM_WORD   = 24'h1B5C28,
  parameter int               KP_SH      = 6,
  parameter int               KI_SH      = 2,
  parameter int               INT_LIM    = 8192,
  parameter int               SWEEP_STEP = 64,
  parameter int               SWEEP_LIM  = 2048,
  parameter int               SWEEP_DIV  = 4,
  parameter int               WIN        = 16,
  parameter int               ENTER_TH   = 64,
  parameter int               EXIT_TH    = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic signed [DATA_W-1:0] i_smp_i,
  input  logic signed [DATA_W-1:0] q_smp_i,
  output logic [PH_W-1:0]          nco_phase_o,
  output logic [ACC_W-1:0]         nco_freq_o,
  output logic                     lock_o
);
  localparam int ERR_W = DATA_W + 2;

  logic signed [ERR_W-1:0] err;
  logic                    err_vld;
  logic signed [ACC_W-1:0] integ, prop, sweep_off;
  logic [ACC_W-1:0]        phase_q;

  costas_phase_det #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_pd (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i),
    .i_i(i_smp_i), .q_i(q_smp_i), .err_o(err), .err_vld_o(err_vld)
  );

  costas_loop_filter #(
    .ERR_W(ERR_W), .ACC_W(ACC_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .INT_LIM(INT_LIM)
  ) u_lf (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_vld_i(err_vld), .err_i(err),
    .integ_o(integ), .prop_o(prop)
  );

  costas_sweep #(
    .ACC_W(ACC_W), .SWEEP_STEP(SWEEP_STEP), .SWEEP_LIM(SWEEP_LIM), .SWEEP_DIV(SWEEP_DIV)
  ) u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(lock_o), .off_o(sweep_off)
  );

  costas_lock_det #(
    .DATA_W(DATA_W), .WIN(WIN), .ENTER_TH(ENTER_TH), .EXIT_TH(EXIT_TH)
  ) u_ld (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(smp_vld_i),
    .i_i(i_smp_i), .q_i(q_smp_i), .lock_o(lock_o)
  );

  assign nco_freq_o = NOM_WORD + $unsigned(integ) + $unsigned(prop) + $unsigned(sweep_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + nco_freq_o;
  end

  assign nco_phase_o = phase_q[ACC_W-1 -: PH_W];
endmodule

// File: rtl/costas_carrier_loop_chk.sv
module costas_carrier_loop_chk #(
  parameter int ACC_W      = 24,
  parameter int INT_LIM    = 8192,
  parameter int SWEEP_STEP = 64,
  parameter int SWEEP_LIM  = 2048
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_vld_i,
  input logic                    lock_i,
  input logic                    err_vld_i,
  input logic signed [ACC_W-1:0] integ_i,
  input logic signed [ACC_W-1:0] sweep_off_i
);
  localparam int AW1 = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ILIM = ACC_W'(INT_LIM);
  localparam logic signed [ACC_W-1:0] SLIM = ACC_W'(SWEEP_LIM);
  localparam logic signed [AW1-1:0]   STP  = AW1'(SWEEP_STEP);

  AST_INT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_i <= ILIM) && (integ_i >= -ILIM)); // R3

  AST_SWEEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_off_i <= SLIM) && (sweep_off_i >= -SLIM)); // R6

  AST_SWEEP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> ((AW1'(sweep_off_i) - AW1'($past(sweep_off_i)) <= STP) &&
                 (AW1'(sweep_off_i) - AW1'($past(sweep_off_i)) >= -STP))); // R6

  AST_SWEEP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(sweep_off_i)); // R7

  AST_IDLE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !err_vld_i); // R9

  AST_INT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_i |=> $stable(integ_i)); // R9

  AST_LOCK_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i != $past(lock_i)) |-> $past(smp_vld_i)); // R8
endmodule

bind costas_carrier_loop costas_carrier_loop_chk #(
  .ACC_W(ACC_W), .INT_LIM(INT_LIM), .SWEEP_STEP(SWEEP_STEP), .SWEEP_LIM(SWEEP_LIM)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .lock_i(lock_o),
  .err_vld_i(err_vld), .integ_i(integ), .sweep_off_i(sweep_off)
);

// File: tb/costas_carrier_loop_tb_top.sv
module costas_carrier_loop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8, ACC_W = 24, PH_W = 10;
  localparam logic [23:0] NOM = 24'h1B5C28;
  localparam int KP = 6, KI = 2, ILIM = 8192;
  localparam int STEP = 64, SLIM = 2048, DIV = 4;
  localparam int WIN = 16, EN_TH = 64, EX_TH = 256;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic signed [DATA_W-1:0] ii = '0, qq = '0;
  logic [PH_W-1:0]  nco_phase;
  logic [ACC_W-1:0] nco_freq;
  logic             lock;

  costas_carrier_loop #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .PH_W(PH_W), .NOM_WORD(NOM), .KP_SH(KP), .KI_SH(KI),
    .INT_LIM(ILIM), .SWEEP_STEP(STEP), .SWEEP_LIM(SLIM), .SWEEP_DIV(DIV),
    .WIN(WIN), .ENTER_TH(EN_TH), .EXIT_TH(EX_TH)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .i_smp_i(ii), .q_smp_i(qq),
    .nco_phase_o(nco_phase), .nco_freq_o(nco_freq), .lock_o(lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_en = 1'b0, done = 1'b0;
  string tag = "R1";

  // reference model state
  int          m_e, m_int, m_prop, m_sw, m_dc, m_sum, m_cnt;
  bit          m_ev, m_up, m_lk;
  logic [23:0] m_acc;

  function automatic int pd_f(int i, int q);
    int si = (i >= 0) ? 1 : -1;
    int sq = (q >= 0) ? 1 : -1;
    return si * q - sq * i;
  endfunction

  function automatic int mag_f(int i, int q);
    int a = (i < 0) ? -i : i;
    int b = (q < 0) ? -q : q;
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic [23:0] m_freq_f();
    return NOM + 24'(m_int) + 24'(m_prop) + 24'(m_sw);
  endfunction

  task automatic model_reset();
    m_e = 0; m_int = 0; m_prop = 0; m_sw = 0; m_dc = 0; m_sum = 0; m_cnt = 0;
    m_ev = 0; m_up = 1; m_lk = 0; m_acc = '0;
  endtask

  task automatic model_step();
    int vi = int'(ii);
    int vq = int'(qq);
    m_acc = m_acc + m_freq_f();
    if (m_ev) begin
      int t = m_int + m_e * (1 << KI);
      if (t > ILIM) t = ILIM;
      if (t < -ILIM) t = -ILIM;
      m_int  = t;
      m_prop = m_e * (1 << KP);
    end
    m_ev = vld;
    if (vld) m_e = pd_f(vi, vq);
    if (!m_lk) begin
      if (m_dc == DIV - 1) begin
        m_dc = 0;
        if (m_up) begin
          m_sw += STEP;
          if (m_sw >= SLIM) begin m_sw = SLIM; m_up = 0; end
        end else begin
          m_sw -= STEP;
          if (m_sw <= -SLIM) begin m_sw = -SLIM; m_up = 1; end
        end
      end else m_dc++;
    end
    if (vld) begin
      if (m_cnt == WIN - 1) begin
        int tot = m_sum + mag_f(vi, vq);
        if (!m_lk && tot < EN_TH) m_lk = 1;
        else if (m_lk && tot > EX_TH) m_lk = 0;
        m_sum = 0; m_cnt = 0;
      end else begin
        m_sum += mag_f(vi, vq);
        m_cnt++;
      end
    end
  endtask

  initial begin
    model_reset();
    forever begin
      @(posedge clk);
      if (!rst_n) model_reset();
      else model_step();
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk);
    if (rst_n && cmp_en) begin
      chk(tag, "freq word", nco_freq, m_freq_f());
      chk(tag, "phase index", nco_phase, m_acc[23 -: PH_W]);
      chk(tag, "lock flag", lock, m_lk);
    end
  end

  task automatic drive(bit v, int i, int q);
    @(negedge clk);
    vld = v; ii = DATA_W'(i); qq = DATA_W'(q);
  endtask

  function automatic int rnd_s();
    return ($urandom_range(1) == 0) ? 1 : -1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] f0;
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "lock in reset", lock, 0);
    chk("R1", "freq in reset", nco_freq, NOM);
    chk("R1", "phase in reset", nco_phase, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2 R4 single sample: e = 3 - 10 = -7
    tag = "R2";
    drive(1, 10, 3);
    drive(0, 0, 0);
    @(negedge clk);
    chk("R2", "freq after one error", nco_freq, 24'(NOM - 28 - 448));
    tag = "R4";
    drive(1, 0, 50);
    drive(0, 0, 0);
    repeat (10) drive(0, 0, 0);

    // R6 sweep triangle with idle strobe
    tag = "R6";
    repeat (600) drive(0, 0, 0);

    // R9 garbage on data while strobe is low
    tag = "R9";
    repeat (200) drive(0, int'($urandom_range(200)) - 100, int'($urandom_range(200)) - 100);

    // R3 integrator saturation: e = +100 each sample
    tag = "R3";
    repeat (80) drive(1, 0, 100);
    repeat (3) drive(0, 0, 0);

    // R5 random mix
    tag = "R5";
    for (int k = 0; k < 2000; k++)
      drive($urandom_range(3) != 0, int'($urandom_range(200)) - 100,
            int'($urandom_range(200)) - 100);

    // R8 diagonal symbols give lock
    tag = "R8";
    repeat (2 * WIN) drive(1, rnd_s() * 40, rnd_s() * 40);
    drive(0, 0, 0);
    chk("R8", "lock after diagonal windows", lock, 1);

    // R7 and R9: locked, strobe low, frequency frozen
    tag = "R7";
    repeat (3) drive(0, 0, 0);
    f0 = nco_freq;
    repeat (40) drive(0, int'($urandom_range(200)) - 100, int'($urandom_range(200)) - 100);
    chk("R7", "freq frozen while locked", nco_freq, f0);
    chk("R9", "lock kept on idle strobe", lock, 1);

    // R8 hysteresis: spread 10 per sample, sum 160 keeps lock
    tag = "R8";
    repeat (3 * WIN) drive(1, rnd_s() * 40, rnd_s() * 30);
    drive(0, 0, 0);
    chk("R8", "lock held between thresholds", lock, 1);

    // R8 off-diagonal symbols drop lock
    repeat (2 * WIN) drive(1, 100, 0);
    drive(0, 0, 0);
    chk("R8", "lock lost", lock, 0);

    // R7 sweep resumes after unlock
    tag = "R7";
    repeat (2) drive(0, 0, 0);
    f0 = nco_freq;
    repeat (2 * DIV) drive(0, 0, 0);
    chk("R7", "sweep resumed", longint'(nco_freq != f0), 1);

    // R8 unlocked loop does not lock on intermediate spread
    tag = "R8";
    repeat (3 * WIN) drive(1, rnd_s() * 40, rnd_s() * 30);
    drive(0, 0, 0);
    chk("R8", "no lock between thresholds", lock, 0);

    tag = "R5";
    for (int k = 0; k < 1000; k++)
      drive($urandom_range(1) != 0, rnd_s() * int'($urandom_range(60)),
            rnd_s() * int'($urandom_range(60)));
    drive(0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule